// File: doc/BRIEF.md
# Interrupt Status Set/Clear Controller

This block keeps a 32-bit word of pending interrupt causes and drives one level-sensitive interrupt line from it. Software reaches it through a small register port. One offset reads the word back. A raise offset ORs a value into the word. An acknowledge offset clears the bits that are set in the written value. Internal logic can also set bits, through a 32-bit vector of one-cycle set pulses and through a dedicated transfer-done pulse that sets bit 8.

The line follows a deliberately asymmetric rule. Any software raise drives it high, even when the raised value is zero. Any internal set pulse also drives it high. Only an acknowledge can bring it low, and only when the word is entirely zero after that acknowledge. An acknowledge that leaves some cause pending keeps the line high. Register reads answer one cycle after the request. Accesses narrower than a full 32-bit word do nothing.

Top module: `irq_setclr_ctl`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears the status word to zero and drives `irq_out` low.
- R2: A word-wide read (`req_size` = 2) at offset 0x24 sets `rsp_valid` in the next cycle, with `rsp_rdata` equal to the status word as it was in the request cycle. A read at any other offset returns 0xFFFFFFFF.
- R3: A word-wide write at offset 0x60 ORs `req_wdata` into the status word and drives `irq_out` high from the next cycle. This holds even when the written value is zero.
- R4: A word-wide write at offset 0x64 clears every status bit that is 1 in `req_wdata`. `irq_out` goes low in the next cycle only if the resulting word is zero; otherwise it stays high.
- R5: Each bit of `hw_set` that is high in a cycle sets that status bit and drives `irq_out` high. If an acknowledge clears the same bit in the same cycle, the set wins.
- R6: A pulse on `xfer_done` sets status bit 8 (value 0x100) and drives `irq_out` high.
- R7: An access with `req_size` other than 2 (0 = byte, 1 = half, 3 = reserved) changes nothing. A read of that kind returns 0xFFFFFFFF.
- R8: Word-wide writes to offsets other than 0x60 and 0x64, including 0x24, leave the status word and `irq_out` unchanged.
- R9: Whenever the status word is nonzero, `irq_out` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the access |
| req_size | input | 2 | Access width: 0 byte, 1 half, 2 word, 3 reserved |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| hw_set | input | 32 | Internal one-cycle set pulses, one per status bit |
| xfer_done | input | 1 | Transfer-complete pulse; sets bit 8 |
| irq_out | output | 1 | Level-sensitive interrupt line |

## Verification
The bench raises zero and checks that the line still goes high. A design that tied the line to a nonzero word would miss this case. It then acknowledges the causes one at a time. A design that dropped the line on any acknowledge would go low while bit 2 is still pending. An internal pulse and an acknowledge of the same bit arrive in the same cycle; a design with the wrong priority would lose that cause and lower the line. Narrow writes and stray writes to the read offset must leave the word untouched; a decoder that ignored width or offset would corrupt the word.

// File: rtl/irq_sc_pkg.sv
package irq_sc_pkg;

    localparam int WORD_W = 32;
    localparam int OFS_W  = 8;

    // Offsets decoded by software drivers; kept fixed.
    localparam logic [OFS_W-1:0] OFS_STATUS = 8'h24;
    localparam logic [OFS_W-1:0] OFS_RAISE  = 8'h60;
    localparam logic [OFS_W-1:0] OFS_ACK    = 8'h64;

    localparam logic [WORD_W-1:0] MISS_DATA = '1;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_RAISE = 2'd2,
        OP_ACK   = 2'd3
    } reg_op_e;

    typedef struct packed {
        reg_op_e           op;
        logic              status_hit;
        logic [WORD_W-1:0] data;
    } reg_cmd_t;

    function automatic logic [WORD_W-1:0] one_hot(input int unsigned pos);
        logic [WORD_W-1:0] v;
        v = '0;
        v[pos] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/irq_sc_decode.sv
module irq_sc_decode
    import irq_sc_pkg::*;
#(
    parameter int ADDR_W = OFS_W
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [WORD_W-1:0] req_wdata,
    output reg_cmd_t          cmd
);

    logic is_word;

    assign is_word = (acc_size_e'(req_size) == ACC_WORD);

    always_comb begin
        cmd            = '0;
        cmd.data       = req_wdata;
        cmd.op         = OP_NONE;
        cmd.status_hit = 1'b0;
        if (req_valid) begin
            if (!req_write) begin
                cmd.op         = OP_READ;
                cmd.status_hit = is_word && (req_addr == ADDR_W'(OFS_STATUS));
            end else if (is_word) begin
                if (req_addr == ADDR_W'(OFS_RAISE)) begin
                    cmd.op = OP_RAISE;
                end else if (req_addr == ADDR_W'(OFS_ACK)) begin
                    cmd.op = OP_ACK;
                end
            end
        end
    end

endmodule

// File: rtl/irq_sc_status.sv
module irq_sc_status
    import irq_sc_pkg::*;
#(
    parameter int DONE_BIT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_cmd_t          cmd,
    input  logic [WORD_W-1:0] hw_set,
    input  logic              xfer_done,
    output logic [WORD_W-1:0] status,
    output logic              set_any,
    output logic              next_zero
);

    localparam logic [WORD_W-1:0] DONE_MASK = one_hot(DONE_BIT);

    logic [WORD_W-1:0] set_vec;
    logic [WORD_W-1:0] raise_vec;
    logic [WORD_W-1:0] clr_vec;
    logic [WORD_W-1:0] status_n;

    assign set_vec   = hw_set | (xfer_done ? DONE_MASK : '0);
    assign raise_vec = (cmd.op == OP_RAISE) ? cmd.data : '0;
    assign clr_vec   = (cmd.op == OP_ACK)   ? cmd.data : '0;

    genvar gi;
    generate
        for (gi = 0; gi < WORD_W; gi++) begin : g_bit
            // A set from any source outranks a same-cycle clear.
            assign status_n[gi] = set_vec[gi] | raise_vec[gi] |
                                  (status[gi] & ~clr_vec[gi]);
        end
    endgenerate

    assign set_any   = |set_vec;
    assign next_zero = (status_n == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else begin
            status <= status_n;
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_ACK) && (hw_set != '0) |=> ((status & $past(hw_set)) == $past(hw_set))) // R5
        else $error("set pulse lost against acknowledge");

    AST_DONE_BIT: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> status[DONE_BIT]) // R6
        else $error("transfer-done bit not set");

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (cmd.op inside {OP_NONE, OP_READ}) && (hw_set == '0) && !xfer_done |=> $stable(status)) // R7
        else $error("status changed without a set or clear source");

endmodule

// File: rtl/irq_sc_line.sv
module irq_sc_line
    import irq_sc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  reg_cmd_t cmd,
    input  logic     set_any,
    input  logic     next_zero,
    output logic     irq_out
);

    logic line_n;

    always_comb begin
        line_n = irq_out;
        if (cmd.op == OP_RAISE || set_any) begin
            line_n = 1'b1;
        end else if (cmd.op == OP_ACK && next_zero) begin
            line_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_out <= 1'b0;
        end else begin
            irq_out <= line_n;
        end
    end

    AST_RAISE_LINE: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_RAISE) |=> irq_out) // R3
        else $error("raise did not assert line");

    AST_DROP_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (rst)
        (cmd.op != OP_ACK) && irq_out |=> irq_out) // R4
        else $error("line fell without acknowledge");

endmodule

// File: rtl/irq_setclr_ctl.sv
module irq_setclr_ctl
    import irq_sc_pkg::*;
#(
    parameter int ADDR_W   = OFS_W,
    parameter int DONE_BIT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    input  logic [WORD_W-1:0] hw_set,
    input  logic              xfer_done,
    output logic              irq_out
);

    reg_cmd_t          cmd;
    logic [WORD_W-1:0] status;
    logic              set_any;
    logic              next_zero;

    irq_sc_decode #(.ADDR_W(ADDR_W)) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .cmd       (cmd)
    );

    irq_sc_status #(.DONE_BIT(DONE_BIT)) u_status (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .hw_set    (hw_set),
        .xfer_done (xfer_done),
        .status    (status),
        .set_any   (set_any),
        .next_zero (next_zero)
    );

    irq_sc_line u_line (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .set_any   (set_any),
        .next_zero (next_zero),
        .irq_out   (irq_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= (cmd.op == OP_READ);
            if (cmd.op == OP_READ) begin
                rsp_rdata <= cmd.status_hit ? status : MISS_DATA;
            end
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (status == '0) && !irq_out) // R1
        else $error("reset did not clear");

    AST_PENDING_LINE: assert property (@(posedge clk) disable iff (rst)
        (status != '0) |-> irq_out) // R9
        else $error("pending cause with line low");

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_write |=> rsp_valid) // R2
        else $error("read response missing");

    AST_ACK_ZERO: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_write && (req_size == 2'd2) && (req_addr == ADDR_W'(OFS_ACK))
        && (hw_set == '0) && !xfer_done |=> (irq_out == (status != '0))) // R4
        else $error("line wrong after acknowledge");

    AST_NARROW_IGNORED: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_write && (req_size != 2'd2) && (hw_set == '0) && !xfer_done
        |=> $stable(status) && $stable(irq_out)) // R7
        else $error("narrow write had an effect");

endmodule

// File: tb/irq_setclr_ctl_bench.sv
module irq_setclr_ctl_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_STAT  = 8'h24;
    localparam logic [7:0] A_RAISE = 8'h60;
    localparam logic [7:0] A_ACK   = 8'h64;
    localparam logic [1:0] SZ_WORD = 2'd2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [31:0] hw_set = '0;
    logic        xfer_done = 1'b0;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_setclr_ctl u_irq_setclr_ctl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .hw_set(hw_set),
        .xfer_done(xfer_done), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [1:0] sz,
                            input logic [31:0] exp);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        check(req, rsp_rdata, exp);
    endtask

    task automatic t_reset;
        check("R1 line after reset", 32'(irq_out), 32'd0);
        rd_check("R1 status after reset", A_STAT, SZ_WORD, 32'h0);
    endtask

    task automatic t_raise_ack;
        wr(A_RAISE, SZ_WORD, 32'h5);
        check("R3 line after raise", 32'(irq_out), 32'd1);
        rd_check("R3 status after raise", A_STAT, SZ_WORD, 32'h5);
        wr(A_ACK, SZ_WORD, 32'h1);
        check("R4 line held with bit pending", 32'(irq_out), 32'd1);
        rd_check("R4 partial ack", A_STAT, SZ_WORD, 32'h4);
        wr(A_ACK, SZ_WORD, 32'h4);
        check("R4 line dropped on zero", 32'(irq_out), 32'd0);
        rd_check("R4 full ack", A_STAT, SZ_WORD, 32'h0);
    endtask

    task automatic t_raise_zero;
        wr(A_RAISE, SZ_WORD, 32'h0);
        check("R3 raise of zero asserts line", 32'(irq_out), 32'd1);
        rd_check("R3 raise of zero status", A_STAT, SZ_WORD, 32'h0);
        wr(A_ACK, SZ_WORD, 32'h0);
        check("R4 ack of zero with empty word drops line", 32'(irq_out), 32'd0);
    endtask

    task automatic t_other_read;
        rd_check("R2 unmapped read", 8'h08, SZ_WORD, 32'hFFFF_FFFF);
    endtask

    task automatic t_hw_set;
        @(negedge clk); hw_set = 32'h30;
        @(negedge clk); hw_set = '0;
        check("R5 line after hw set", 32'(irq_out), 32'd1);
        rd_check("R5 status after hw set", A_STAT, SZ_WORD, 32'h30);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = A_ACK; req_size = SZ_WORD;
        req_wdata = 32'h30; hw_set = 32'h10;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; hw_set = '0;
        check("R5 set wins over ack line", 32'(irq_out), 32'd1);
        rd_check("R5 set wins over ack status", A_STAT, SZ_WORD, 32'h10);
        wr(A_ACK, SZ_WORD, 32'h10);
        check("R4 clear after collision", 32'(irq_out), 32'd0);
    endtask

    task automatic t_done;
        @(negedge clk); xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
        check("R6 line after done", 32'(irq_out), 32'd1);
        rd_check("R6 done bit 8", A_STAT, SZ_WORD, 32'h100);
        wr(A_ACK, SZ_WORD, 32'h100);
        check("R6 cleared", 32'(irq_out), 32'd0);
    endtask

    task automatic t_narrow;
        wr(A_RAISE, 2'd1, 32'hFF);
        check("R7 half raise ignored line", 32'(irq_out), 32'd0);
        rd_check("R7 half raise ignored status", A_STAT, SZ_WORD, 32'h0);
        wr(A_RAISE, 2'd0, 32'hFF);
        check("R7 byte raise ignored line", 32'(irq_out), 32'd0);
        rd_check("R7 narrow read", A_STAT, 2'd3, 32'hFFFF_FFFF);
        wr(A_RAISE, SZ_WORD, 32'h3);
        wr(A_ACK, 2'd0, 32'h3);
        rd_check("R7 byte ack ignored", A_STAT, SZ_WORD, 32'h3);
        wr(A_ACK, SZ_WORD, 32'h3);
    endtask

    task automatic t_stray;
        wr(A_STAT, SZ_WORD, 32'hDEAD_BEEF);
        check("R8 write to status offset line", 32'(irq_out), 32'd0);
        rd_check("R8 write to status offset", A_STAT, SZ_WORD, 32'h0);
        wr(8'h40, SZ_WORD, 32'h1);
        rd_check("R8 write to unmapped offset", A_STAT, SZ_WORD, 32'h0);
    endtask

    task automatic t_mid_reset;
        wr(A_RAISE, SZ_WORD, 32'hF);
        check("R9 line with pending causes", 32'(irq_out), 32'd1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 line after mid reset", 32'(irq_out), 32'd0);
        rd_check("R1 status after mid reset", A_STAT, SZ_WORD, 32'h0);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_raise_ack();
        t_raise_zero();
        t_other_read();
        t_hw_set();
        t_done();
        t_narrow();
        t_stray();
        t_mid_reset();
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=done");
            summary();
            $finish;
        end
    end

endmodule